// File: doc/BRIEF.md
# Split Receive Descriptor Writeback Formatter

This block assembles the fields that a receive engine writes back into a descriptor once that descriptor's buffers have been filled. It takes the following inputs:

- the descriptor mode;
- the byte counts that were placed in the header buffer and in the packet buffer;
- the outcome of the header-split decision: whether a split header was produced, whether the header overflowed its buffer, and the parsed header length;
- a flag that marks the final descriptor of a frame.

From these it produces the packet length to report, a 16-bit header-info word and a 32-bit status/error word.

One request is accepted in any cycle in which `valid_i` is high. The formatted result is registered and appears one clock later, with a single-cycle `valid_o` pulse. The DMA side then copies the three output words into the descriptor's writeback image. The receive-hash, packet-type and checksum fields are not built here, so every bit not named below is zero.

Top module: `rxd_wb_fmt`

## Requirements
- R1: `valid_o` is high in exactly the cycles that follow a cycle in which `valid_i` was high, so each accepted request gives one pulse one clock later.
- R2: In mode 0 (legacy) and mode 1 (one-buffer), `len_o` equals the packet-buffer count `pkt_cnt_i`.
- R3: In mode 3 (split-always), `len_o` equals `pkt_cnt_i` only, whatever the flags are.
- R4: In mode 2 (header split), when `sph_i` and `hbo_i` are both high or both low, `len_o` equals `hdr_cnt_i + pkt_cnt_i`, with no carry lost.
- R5: In mode 2, when exactly one of `sph_i` and `hbo_i` is high, `len_o` equals `pkt_cnt_i`.
- R6: In modes 2 and 3, `hdr_info_o[14:5]` holds bits 9:0 of `hdr_len_i`, and the higher length bits are dropped. `hdr_info_o[4:0]` is zero.
- R7: In modes 2 and 3, `hdr_info_o[15]` equals `sph_i`.
- R8: In modes 2 and 3, `status_o[23]` equals `hbo_i`.
- R9: In modes 0 and 1, `hdr_info_o` is zero and `status_o[23]` is zero, whatever the split inputs are.
- R10: On every result, `status_o[0]` (descriptor done) is 1 and `status_o[1]` (end of packet) equals `last_i`. All other status bits except bit 23 are zero.
- R11: After reset, all outputs are zero. In a cycle with `valid_i` low, `len_o`, `hdr_info_o` and `status_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 2 | Descriptor mode: 0 legacy, 1 one-buffer, 2 header split, 3 split-always |
| hdr_cnt_i | input | CNT_W | Bytes written to the header buffer |
| pkt_cnt_i | input | CNT_W | Bytes written to the packet buffer |
| sph_i | input | 1 | Split-header flag from the split decision |
| hbo_i | input | 1 | Header-overflow flag from the split decision |
| hdr_len_i | input | HLEN_IW | Header length from the split decision |
| last_i | input | 1 | Final descriptor of the frame |
| valid_o | output | 1 | Result strobe, one cycle |
| len_o | output | CNT_W+1 | Reported packet length |
| hdr_info_o | output | 16 | Header-info word |
| status_o | output | 32 | Status/error word |

## Verification
The assertions sample each input only in the cycle in which `valid_i` is high. They therefore assume that the requester holds a stable, known value on every input during that cycle, and that inputs outside those cycles carry no meaning. The stimulus follows the same rule: it changes all inputs together away from the clock edge, and during idle cycles it deliberately drives unrelated values, which exercises the hold requirement. The flags are driven in all four combinations in every mode, including an overflow flag with no split-header flag, which the block treats like any other case of differing flags.

// File: rtl/rxd_wb_pkg.sv
package rxd_wb_pkg;
  typedef enum logic [1:0] {
    MODE_LEGACY  = 2'd0,
    MODE_ONEBUF  = 2'd1,
    MODE_HSPLIT  = 2'd2,
    MODE_SPLIT_A = 2'd3
  } rxd_mode_e;

  localparam int HINFO_W  = 16;
  localparam int STAT_W   = 32;
  localparam int HLEN_FW  = 10;
  localparam int HLEN_LSB = 5;
  localparam int SPH_BIT  = 15;
  localparam int HBO_BIT  = 23;
  localparam int DONE_BIT = 0;
  localparam int EOP_BIT  = 1;

  function automatic logic is_split(rxd_mode_e m);
    return (m == MODE_HSPLIT) || (m == MODE_SPLIT_A);
  endfunction
endpackage

// File: rtl/rxd_len_sel.sv
module rxd_len_sel
  import rxd_wb_pkg::*;
#(
  parameter int CNT_W = 15,
  localparam int LEN_W = CNT_W + 1
) (
  input  rxd_mode_e          mode_i,
  input  logic [CNT_W-1:0]   hdr_cnt_i,
  input  logic [CNT_W-1:0]   pkt_cnt_i,
  input  logic               sph_i,
  input  logic               hbo_i,
  output logic [LEN_W-1:0]   len_o
);
  logic [LEN_W-1:0] sum_w;
  logic [LEN_W-1:0] pkt_w;
  logic             use_sum;

  assign sum_w = {1'b0, hdr_cnt_i} + {1'b0, pkt_cnt_i};
  assign pkt_w = {1'b0, pkt_cnt_i};

  // sum only in plain header split with matching flags
  always_comb begin
    use_sum = 1'b0;
    if (mode_i == MODE_HSPLIT) use_sum = (sph_i == hbo_i);
  end

  assign len_o = use_sum ? sum_w : pkt_w;
endmodule

// File: rtl/rxd_hinfo_pack.sv
module rxd_hinfo_pack
  import rxd_wb_pkg::*;
#(
  parameter int HLEN_IW = 16
) (
  input  rxd_mode_e            mode_i,
  input  logic [HLEN_IW-1:0]   hdr_len_i,
  input  logic                 sph_i,
  output logic [HINFO_W-1:0]   hinfo_o
);
  localparam int KEEP_W = (HLEN_IW < HLEN_FW) ? HLEN_IW : HLEN_FW;

  logic [HLEN_FW-1:0] fld;

  generate
    if (HLEN_IW >= HLEN_FW) begin : g_trunc
      assign fld = hdr_len_i[HLEN_FW-1:0];
    end else begin : g_pad
      assign fld = {{(HLEN_FW-KEEP_W){1'b0}}, hdr_len_i[KEEP_W-1:0]};
    end
  endgenerate

  always_comb begin
    hinfo_o = '0;
    if (is_split(mode_i)) begin
      hinfo_o[HLEN_LSB +: HLEN_FW] = fld;
      hinfo_o[SPH_BIT]             = sph_i;
    end
  end
endmodule

// File: rtl/rxd_status_pack.sv
module rxd_status_pack
  import rxd_wb_pkg::*;
(
  input  rxd_mode_e           mode_i,
  input  logic                hbo_i,
  input  logic                last_i,
  output logic [STAT_W-1:0]   stat_o
);
  always_comb begin
    stat_o           = '0;
    stat_o[DONE_BIT] = 1'b1;
    stat_o[EOP_BIT]  = last_i;
    stat_o[HBO_BIT]  = is_split(mode_i) & hbo_i;
  end
endmodule

// File: rtl/rxd_wb_fmt.sv
module rxd_wb_fmt
  import rxd_wb_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int HLEN_IW = 16,
  localparam int LEN_W  = CNT_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [1:0]           mode_i,
  input  logic [CNT_W-1:0]     hdr_cnt_i,
  input  logic [CNT_W-1:0]     pkt_cnt_i,
  input  logic                 sph_i,
  input  logic                 hbo_i,
  input  logic [HLEN_IW-1:0]   hdr_len_i,
  input  logic                 last_i,
  output logic                 valid_o,
  output logic [LEN_W-1:0]     len_o,
  output logic [15:0]          hdr_info_o,
  output logic [31:0]          status_o
);
  rxd_mode_e          mode;
  logic [LEN_W-1:0]   len_d;
  logic [HINFO_W-1:0] hinfo_d;
  logic [STAT_W-1:0]  stat_d;

  assign mode = rxd_mode_e'(mode_i);

  rxd_len_sel #(.CNT_W(CNT_W)) u_len (
    .mode_i    (mode),
    .hdr_cnt_i (hdr_cnt_i),
    .pkt_cnt_i (pkt_cnt_i),
    .sph_i     (sph_i),
    .hbo_i     (hbo_i),
    .len_o     (len_d)
  );

  rxd_hinfo_pack #(.HLEN_IW(HLEN_IW)) u_hinfo (
    .mode_i    (mode),
    .hdr_len_i (hdr_len_i),
    .sph_i     (sph_i),
    .hinfo_o   (hinfo_d)
  );

  rxd_status_pack u_stat (
    .mode_i (mode),
    .hbo_i  (hbo_i),
    .last_i (last_i),
    .stat_o (stat_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      len_o      <= '0;
      hdr_info_o <= '0;
      status_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        len_o      <= len_d;
        hdr_info_o <= hinfo_d;
        status_o   <= stat_d;
      end
    end
  end
endmodule

// File: rtl/rxd_wb_fmt_chk.sv
module rxd_wb_fmt_chk #(
  parameter int CNT_W   = 15,
  parameter int HLEN_IW = 16,
  localparam int LEN_W  = CNT_W + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [1:0]         mode_i,
  input logic [CNT_W-1:0]   hdr_cnt_i,
  input logic [CNT_W-1:0]   pkt_cnt_i,
  input logic               sph_i,
  input logic               hbo_i,
  input logic [HLEN_IW-1:0] hdr_len_i,
  input logic               last_i,
  input logic               valid_o,
  input logic [LEN_W-1:0]   len_o,
  input logic [15:0]        hdr_info_o,
  input logic [31:0]        status_o
);
  assert_valid_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_len_plain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i[1]) |=> len_o == {1'b0, $past(pkt_cnt_i)});
  assert_len_always_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd3) |=> len_o == {1'b0, $past(pkt_cnt_i)});
  assert_len_sum_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd2 && sph_i == hbo_i) |=>
      len_o == ({1'b0, $past(hdr_cnt_i)} + {1'b0, $past(pkt_cnt_i)}));
  assert_len_pkt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd2 && sph_i != hbo_i) |=> len_o == {1'b0, $past(pkt_cnt_i)});
  assert_hlen_field_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i[1]) |=> hdr_info_o[14:5] == $past(hdr_len_i[9:0]) && hdr_info_o[4:0] == 5'd0);
  assert_sph_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i[1]) |=> hdr_info_o[15] == $past(sph_i));
  assert_hbo_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i[1]) |=> status_o[23] == $past(hbo_i));
  assert_nosplit_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i[1]) |=> hdr_info_o == 16'd0 && !status_o[23]);
  assert_status_bits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> status_o[0] && $countones(status_o & 32'hFF7F_FFFC) == 0);
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(len_o) && $stable(hdr_info_o) && $stable(status_o));
endmodule

bind rxd_wb_fmt rxd_wb_fmt_chk #(.CNT_W(CNT_W), .HLEN_IW(HLEN_IW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .mode_i     (mode_i),
  .hdr_cnt_i  (hdr_cnt_i),
  .pkt_cnt_i  (pkt_cnt_i),
  .sph_i      (sph_i),
  .hbo_i      (hbo_i),
  .hdr_len_i  (hdr_len_i),
  .last_i     (last_i),
  .valid_o    (valid_o),
  .len_o      (len_o),
  .hdr_info_o (hdr_info_o),
  .status_o   (status_o)
);

// File: tb/rxd_wb_fmt_bench.sv
`timescale 1ns/1ps
module rxd_wb_fmt_bench;
  localparam int CNT_W   = 15;
  localparam int HLEN_IW = 16;
  localparam int LEN_W   = CNT_W + 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               valid_i = 1'b0;
  logic [1:0]         mode_i = '0;
  logic [CNT_W-1:0]   hdr_cnt_i = '0;
  logic [CNT_W-1:0]   pkt_cnt_i = '0;
  logic               sph_i = 1'b0;
  logic               hbo_i = 1'b0;
  logic [HLEN_IW-1:0] hdr_len_i = '0;
  logic               last_i = 1'b0;
  logic               valid_o;
  logic [LEN_W-1:0]   len_o;
  logic [15:0]        hdr_info_o;
  logic [31:0]        status_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  int exp_len = 0, exp_hinfo = 0;
  longint exp_stat = 0;
  int len_tag = 11;
  bit exp_split = 1'b0;

  always #4 clk = ~clk;

  rxd_wb_fmt #(.CNT_W(CNT_W), .HLEN_IW(HLEN_IW)) u_rxd_wb_fmt (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .hdr_cnt_i(hdr_cnt_i), .pkt_cnt_i(pkt_cnt_i), .sph_i(sph_i), .hbo_i(hbo_i),
    .hdr_len_i(hdr_len_i), .last_i(last_i), .valid_o(valid_o), .len_o(len_o),
    .hdr_info_o(hdr_info_o), .status_o(status_o)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic string tag(int n);
    return $sformatf("R%0d", n);
  endfunction

  task automatic step(bit v, int m, int h, int p, bit s, bit o, int hl, bit l);
    valid_i = v; mode_i = 2'(m); hdr_cnt_i = CNT_W'(h); pkt_cnt_i = CNT_W'(p);
    sph_i = s; hbo_i = o; hdr_len_i = HLEN_IW'(hl); last_i = l;
    if (v) begin
      exp_split = (m >= 2);
      if (m < 2)          begin exp_len = p;     len_tag = 2; end
      else if (m == 3)    begin exp_len = p;     len_tag = 3; end
      else if (s == o)    begin exp_len = h + p; len_tag = 4; end
      else                begin exp_len = p;     len_tag = 5; end
      exp_hinfo = exp_split ? (((hl & 1023) << 5) | (int'(s) << 15)) : 0;
      exp_stat  = 1 | (longint'(l) << 1) | ((exp_split && o) ? (longint'(1) << 23) : 0);
    end
    @(negedge clk);
    chk("R1 valid_o", longint'(valid_o), longint'(v));
    if (!v) begin
      chk("R11 hold len", longint'(len_o), longint'(exp_len));
      chk("R11 hold hdr_info", longint'(hdr_info_o), longint'(exp_hinfo));
      chk("R11 hold status", longint'(status_o), exp_stat);
    end else begin
      chk({tag(len_tag), " len"}, longint'(len_o), longint'(exp_len));
      if (exp_split) begin
        chk("R6 hdr_info[14:0]", longint'(hdr_info_o[14:0]), longint'(exp_hinfo & 32'h7FFF));
        chk("R7 hdr_info[15]", longint'(hdr_info_o[15]), longint'((exp_hinfo >> 15) & 1));
        chk("R8 status[23]", longint'(status_o[23]), (exp_stat >> 23) & 1);
      end else begin
        chk("R9 hdr_info", longint'(hdr_info_o), 0);
        chk("R9 status[23]", longint'(status_o[23]), 0);
      end
      chk("R10 status", longint'(status_o & 32'hFF7F_FFFF), exp_stat & 32'hFF7F_FFFF);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    chk("R11 reset valid_o", longint'(valid_o), 0);
    chk("R11 reset len", longint'(len_o), 0);
    chk("R11 reset hdr_info", longint'(hdr_info_o), 0);
    chk("R11 reset status", longint'(status_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: every mode with every flag pair
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 4; f++)
        step(1'b1, m, 40 + f, 1000 + 7 * m, f[0], f[1], 60 + m, f[0] ^ f[1]);
    // length masking and count extremes
    step(1'b1, 2, 32767, 32767, 1'b1, 1'b1, 16'hFFFF, 1'b1);
    step(1'b1, 3, 32767, 32767, 1'b1, 1'b0, 16'h0400, 1'b0);
    step(1'b1, 2, 0, 0, 1'b0, 1'b0, 1023, 1'b1);
    step(1'b1, 0, 500, 9, 1'b1, 1'b1, 16'h03FF, 1'b0);
    // idle cycles with garbage inputs must not disturb outputs
    step(1'b0, 3, 123, 456, 1'b1, 1'b1, 777, 1'b1);
    step(1'b0, 1, 9, 9, 1'b0, 1'b1, 5, 1'b0);
    step(1'b1, 1, 12, 34, 1'b1, 1'b1, 99, 1'b1);
    step(1'b0, 2, 1, 2, 1'b1, 1'b0, 3, 1'b0);
    // pseudo-random mix with gaps
    seed = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      int r1, r2;
      seed = seed * 1103515245 + 12345; r1 = (seed >>> 8) & 32'h00FF_FFFF;
      seed = seed * 1103515245 + 12345; r2 = (seed >>> 8) & 32'h00FF_FFFF;
      step(r1[0] | r1[1], r1[3:2], r2 & 32'h7FFF, (r1 >> 4) & 32'h7FFF,
           r2[15], r2[16], (r2 >> 3) & 32'hFFFF, r1[20]);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule